// File: doc/BRIEF.md
# Packetized Ownership Mailbox Controller

This block is the device end of a command mailbox that a host reaches through a plain 64-bit register bus. Word address 0 is a 64-bit control word. Word addresses 1 to 128 form a 1024-byte data window, and that window is only ever accessed as whole qwords. The mailbox starts out free. The host claims it by writing the first qword of its payload into the window, and that qword lands at window word address 1. A command is then launched through the control word. Write commands take their command code from the last payload qword. Read commands take it from the first qword. The controller hands each command to a local responder port and waits for a result status.

For a read, a successful result also carries a total message length. The controller then pulls the reply qword by qword from the responder's stream into the window. The reply is cut into packets of at most 1024 bytes, and a message can be at most four packets long. Each packet is presented to the host with ready, start-of-message and end-of-message marks, the packet byte count and the total message size. The host acknowledges a packet by writing the complete bit. That acknowledgement releases ownership after the last packet, after any error or timeout result, or when no command has yet been launched.

The control word is decoded as follows:

| Bits | Field |
|---|---|
| 0 | run/busy |
| 1 | direction, 1 = write |
| 2 | start-of-message (SOM) |
| 3 | end-of-message (EOM) |
| 5:4 | owner, 0 = free, 1 = in-band host |
| 6 | complete; it is write-to-trigger and always reads 0 |
| 7 | ready |
| 15:8 | status |
| 31:16 | packet size in bytes |
| 47:32 | reads as 0 |
| 63:48 | total message size |

Top module: `mbx_ctrl`

## Requirements
- R1: After reset, the control word reads as 0, req_valid is low and dat_ready is low.
- R2: While the mailbox is free, control-word writes have no effect and window writes to any word other than address 1 are dropped. A write to address 1 stores that qword and sets the owner field to 1.
- R3: The host launches a command by writing the control word with run, SOM and EOM all set, while it owns the mailbox and no command is active. In the cycle after that write, req_valid is high for exactly one cycle. With it come req_write (the direction bit), req_len (bits 31:16 of the written word) and req_code. For a write command, req_code is the low byte of window qword ceil(len/8)-1; for a read command it is the low byte of qword 0. While the command waits, the control word shows run=1 and ready=0.
- R4: A command code other than 0x04, 0x08, 0x10 or 0x14 issues no request. Status becomes 0x02, ready rises and run clears.
- R5: When rsp_valid arrives for a write command, or for a read command whose status is not 0x40, status takes rsp_status, ready rises and run clears. A read that fails this way also reports a packet size of 0.
- R6: If rsp_valid has not arrived TIMEOUT_CYC cycles after the command, status becomes 0x80, ready rises and the packet size reads 0.
- R7: A successful read (status 0x40) reports rsp_msg_len in bits 63:48. It is split into packets of exactly 1024 bytes, except the last, which may be shorter. SOM is 1 only on the first packet and EOM only on the last. A message length of 0 gives a single empty packet with EOM set.
- R8: Reply qwords are written into the window in arrival order, one per cycle while dat_valid and dat_ready are both high, starting at window address 1. A packet takes ceil(bytes/8) qwords, and ready rises on the edge that accepts the last of them.
- R9: Writing the complete bit while a non-final packet is ready clears ready and starts loading the next packet. The complete bit always reads as 0.
- R10: Writing the complete bit after the final packet, after an error or timeout result, or while owned with no command active releases the mailbox, and the control word then reads 0.
- R11: A read reply longer than 4096 bytes, or a write command with a request size above 1024 bytes, yields status 0x03 with no data.
- R12: While a command is waiting or a packet is loading, writes of the complete bit and host writes to the window have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | 8 | Qword address: 0 is the control word, 1..128 the window |
| bus_wdata | input | 64 | Write data |
| bus_rdata | output | 64 | Combinational read data for bus_addr |
| req_valid | output | 1 | One-cycle command request to the responder |
| req_write | output | 1 | Direction of the requested command |
| req_code | output | 8 | Command code |
| req_len | output | 16 | Request size in bytes |
| rsp_valid | input | 1 | Responder result strobe |
| rsp_status | input | 8 | Result status |
| rsp_msg_len | input | 16 | Total reply length in bytes for reads |
| dat_valid | input | 1 | Reply qword valid |
| dat_qword | input | 64 | Reply qword |
| dat_ready | output | 1 | Controller is loading a packet |

## Verification
Reads are combinational, so the control word and window contents reflect a bus write from the half cycle after the edge that took it. The bench samples them half a cycle after each falling edge. req_valid is due in the cycle directly after the command write. A responder result is visible after the edge that samples rsp_valid. A timeout appears exactly TIMEOUT_CYC edges after the command edge, and the bench checks both the cycle before and the cycle of expiry. A packet's ready is due on the edge that accepts its final qword. A behavioural model advanced on every rising edge predicts all of these, and it is compared against the outputs each cycle.

// File: rtl/mbx_pkg.sv
package mbx_pkg;

    typedef enum logic [2:0] {
        PH_IDLE = 3'd0,
        PH_WAIT = 3'd1,
        PH_FILL = 3'd2,
        PH_HOLD = 3'd3,
        PH_DONE = 3'd4
    } phase_t;

    localparam logic [7:0] ST_OK      = 8'h40;
    localparam logic [7:0] ST_TIMEOUT = 8'h80;
    localparam logic [7:0] ST_BADCODE = 8'h02;
    localparam logic [7:0] ST_SIZE    = 8'h03;

    localparam int CB_RUN  = 0;
    localparam int CB_DIR  = 1;
    localparam int CB_SOM  = 2;
    localparam int CB_EOM  = 3;
    localparam int CB_CMPL = 6;
    localparam int CB_PSZ  = 16;

    typedef struct packed {
        logic        owner;
        phase_t      phase;
        logic        run;
        logic        dir;
        logic        som;
        logic        eom;
        logic        rdy;
        logic [7:0]  status;
        logic [15:0] psize;
        logic [15:0] msgsz;
        logic [15:0] rem;
        logic [15:0] fidx;
        logic [15:0] fqw;
        logic        req;
        logic        req_write;
        logic [7:0]  req_code;
        logic [15:0] req_len;
    } mbx_state_t;

    function automatic logic code_known(input logic [7:0] c);
        return (c == 8'h04) || (c == 8'h08) || (c == 8'h10) || (c == 8'h14);
    endfunction

endpackage

// File: rtl/mbx_window.sv
module mbx_window #(
    parameter int DEPTH = 128,
    parameter int DW    = 64,
    localparam int IW   = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          we,
    input  logic [IW-1:0] widx,
    input  logic [DW-1:0] wval,
    input  logic [IW-1:0] ridx_a,
    output logic [DW-1:0] rdata_a,
    input  logic [IW-1:0] ridx_b,
    output logic [DW-1:0] rdata_b
);
    logic [DW-1:0] mem [DEPTH];

    always_ff @(posedge clk) begin
        if (we) begin
            mem[widx] <= wval;
        end
    end

    assign rdata_a = mem[ridx_a];
    assign rdata_b = mem[ridx_b];
endmodule

// File: rtl/mbx_timer.sv
module mbx_timer #(
    parameter int LIMIT = 64,
    localparam int CW   = $clog2(LIMIT + 1)
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clr,
    input  logic run,
    output logic expired
);
    logic [CW-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (clr) begin
            cnt_d = '0;
        end else if (run && !expired) begin
            cnt_d = cnt_q + CW'(1);
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_d;
        end
    end

    assign expired = run && (cnt_q == CW'(LIMIT - 1));
endmodule

// File: rtl/mbx_pack.sv
module mbx_pack #(
    parameter int WIN_BYTES = 1024
) (
    input  logic [15:0] rem,
    output logic [15:0] pkt_bytes,
    output logic [15:0] pkt_qw,
    output logic        last
);
    localparam logic [15:0] WB = 16'(WIN_BYTES);
    logic [16:0] sum;

    always_comb begin
        last      = (rem <= WB);
        pkt_bytes = last ? rem : WB;
        sum       = {1'b0, pkt_bytes} + 17'd7;
        pkt_qw    = sum[16:1] >> 2;
    end
endmodule

// File: rtl/mbx_ctrl.sv
module mbx_ctrl
    import mbx_pkg::*;
#(
    parameter int WIN_BYTES   = 1024,
    parameter int MAX_PKTS    = 4,
    parameter int TIMEOUT_CYC = 64,
    localparam int WIN_QW     = WIN_BYTES / 8,
    localparam int AW         = $clog2(WIN_QW + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          bus_wr,
    input  logic [AW-1:0] bus_addr,
    input  logic [63:0]   bus_wdata,
    output logic [63:0]   bus_rdata,
    output logic          req_valid,
    output logic          req_write,
    output logic [7:0]    req_code,
    output logic [15:0]   req_len,
    input  logic          rsp_valid,
    input  logic [7:0]    rsp_status,
    input  logic [15:0]   rsp_msg_len,
    input  logic          dat_valid,
    input  logic [63:0]   dat_qword,
    output logic          dat_ready
);
    localparam int IW = $clog2(WIN_QW);
    localparam logic [AW-1:0] LAST_ADDR = AW'(WIN_QW);
    localparam logic [15:0]   WB16      = 16'(WIN_BYTES);
    localparam logic [15:0]   MAX_MSG   = 16'(WIN_BYTES * MAX_PKTS);

    mbx_state_t st_d, st_q;

    logic          win_we;
    logic [IW-1:0] win_widx;
    logic [63:0]   win_wval;
    logic [IW-1:0] win_aidx, code_idx;
    logic [63:0]   win_a, win_b;
    logic          tmr_clr, tmr_exp;
    logic [15:0]   pk_rem, pk_bytes, pk_qw;
    logic          pk_last;

    logic          ctrl_wr, win_wr, cmpl_wr, start_wr;
    logic [15:0]   cmd_len;
    logic          cmd_dir;
    logic [16:0]   cmd_qw;
    logic [7:0]    cmd_code;

    logic          cur_rdy, cur_eom, cur_owner;
    logic [15:0]   cur_psize;

    mbx_window #(.DEPTH(WIN_QW), .DW(64)) u_win (
        .clk     (clk),
        .we      (win_we),
        .widx    (win_widx),
        .wval    (win_wval),
        .ridx_a  (win_aidx),
        .rdata_a (win_a),
        .ridx_b  (code_idx),
        .rdata_b (win_b)
    );

    mbx_timer #(.LIMIT(TIMEOUT_CYC)) u_tmr (
        .clk     (clk),
        .rst_n   (rst_n),
        .clr     (tmr_clr),
        .run     (st_q.phase == PH_WAIT),
        .expired (tmr_exp)
    );

    mbx_pack #(.WIN_BYTES(WIN_BYTES)) u_pack (
        .rem       (pk_rem),
        .pkt_bytes (pk_bytes),
        .pkt_qw    (pk_qw),
        .last      (pk_last)
    );

    // Decode of the bus access and the command word.
    always_comb begin
        ctrl_wr  = bus_wr && (bus_addr == '0);
        win_wr   = bus_wr && (bus_addr != '0) && (bus_addr <= LAST_ADDR);
        cmpl_wr  = ctrl_wr && bus_wdata[CB_CMPL];
        start_wr = ctrl_wr && bus_wdata[CB_RUN] && bus_wdata[CB_SOM] && bus_wdata[CB_EOM];
        cmd_len  = bus_wdata[CB_PSZ +: 16];
        cmd_dir  = bus_wdata[CB_DIR];
        cmd_qw   = ({1'b0, cmd_len} + 17'd7) >> 3;
        if (cmd_dir && (cmd_qw != 17'd0) && (cmd_qw <= 17'(WIN_QW))) begin
            code_idx = IW'(cmd_qw - 17'd1);
        end else begin
            code_idx = '0;
        end
        cmd_code = win_b[7:0];
        win_aidx = IW'(bus_addr - AW'(1));
        pk_rem   = (st_q.phase == PH_WAIT) ? rsp_msg_len : (st_q.rem - WB16);
    end

    // Next-state computation.
    always_comb begin
        st_d     = st_q;
        st_d.req = 1'b0;
        win_we   = 1'b0;
        win_widx = win_aidx;
        win_wval = bus_wdata;
        tmr_clr  = 1'b0;

        unique case (st_q.phase)
            PH_IDLE: begin
                if (!st_q.owner) begin
                    if (bus_wr && (bus_addr == AW'(1))) begin
                        win_we     = 1'b1;
                        st_d.owner = 1'b1;
                    end
                end else if (cmpl_wr) begin
                    st_d = '0;
                end else if (start_wr) begin
                    st_d.run    = 1'b1;
                    st_d.dir    = cmd_dir;
                    st_d.som    = 1'b1;
                    st_d.eom    = 1'b1;
                    st_d.rdy    = 1'b0;
                    st_d.status = 8'h00;
                    st_d.psize  = cmd_len;
                    st_d.msgsz  = 16'h0000;
                    if (!code_known(cmd_code)) begin
                        st_d.status = ST_BADCODE;
                        st_d.run    = 1'b0;
                        st_d.rdy    = 1'b1;
                        st_d.phase  = PH_DONE;
                    end else if (cmd_dir && (cmd_len > WB16)) begin
                        st_d.status = ST_SIZE;
                        st_d.run    = 1'b0;
                        st_d.rdy    = 1'b1;
                        st_d.phase  = PH_DONE;
                    end else begin
                        st_d.phase     = PH_WAIT;
                        st_d.req       = 1'b1;
                        st_d.req_write = cmd_dir;
                        st_d.req_code  = cmd_code;
                        st_d.req_len   = cmd_len;
                        tmr_clr        = 1'b1;
                    end
                end else if (win_wr) begin
                    win_we = 1'b1;
                end
            end

            PH_WAIT: begin
                if (rsp_valid) begin
                    st_d.run = 1'b0;
                    st_d.rdy = 1'b1;
                    if (st_q.dir) begin
                        st_d.status = rsp_status;
                        st_d.phase  = PH_DONE;
                    end else if (rsp_status != ST_OK) begin
                        st_d.status = rsp_status;
                        st_d.psize  = 16'h0000;
                        st_d.phase  = PH_DONE;
                    end else if (rsp_msg_len > MAX_MSG) begin
                        st_d.status = ST_SIZE;
                        st_d.psize  = 16'h0000;
                        st_d.phase  = PH_DONE;
                    end else begin
                        st_d.status = ST_OK;
                        st_d.msgsz  = rsp_msg_len;
                        st_d.som    = 1'b1;
                        st_d.rem    = rsp_msg_len;
                        if (rsp_msg_len == 16'h0000) begin
                            st_d.psize = 16'h0000;
                            st_d.eom   = 1'b1;
                            st_d.phase = PH_HOLD;
                        end else begin
                            st_d.psize = pk_bytes;
                            st_d.eom   = pk_last;
                            st_d.fidx  = 16'h0000;
                            st_d.fqw   = pk_qw;
                            st_d.run   = 1'b1;
                            st_d.rdy   = 1'b0;
                            st_d.phase = PH_FILL;
                        end
                    end
                end else if (tmr_exp) begin
                    st_d.status = ST_TIMEOUT;
                    st_d.psize  = 16'h0000;
                    st_d.run    = 1'b0;
                    st_d.rdy    = 1'b1;
                    st_d.phase  = PH_DONE;
                end
            end

            PH_FILL: begin
                if (dat_valid) begin
                    win_we   = 1'b1;
                    win_widx = st_q.fidx[IW-1:0];
                    win_wval = dat_qword;
                    if (st_q.fidx == (st_q.fqw - 16'd1)) begin
                        st_d.rdy   = 1'b1;
                        st_d.run   = 1'b0;
                        st_d.phase = PH_HOLD;
                    end else begin
                        st_d.fidx = st_q.fidx + 16'd1;
                    end
                end
            end

            PH_HOLD: begin
                if (cmpl_wr) begin
                    if (st_q.eom) begin
                        st_d = '0;
                    end else begin
                        st_d.rem   = pk_rem;
                        st_d.som   = 1'b0;
                        st_d.psize = pk_bytes;
                        st_d.eom   = pk_last;
                        st_d.fidx  = 16'h0000;
                        st_d.fqw   = pk_qw;
                        st_d.run   = 1'b1;
                        st_d.rdy   = 1'b0;
                        st_d.phase = PH_FILL;
                    end
                end
            end

            PH_DONE: begin
                if (cmpl_wr) begin
                    st_d = '0;
                end
            end

            default: begin
                st_d = '0;
            end
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    // Read mux and outputs.
    always_comb begin
        if (bus_addr == '0) begin
            bus_rdata = {st_q.msgsz, 16'h0000, st_q.psize, st_q.status, st_q.rdy,
                         1'b0, 1'b0, st_q.owner, st_q.eom, st_q.som, st_q.dir, st_q.run};
        end else if (bus_addr <= LAST_ADDR) begin
            bus_rdata = win_a;
        end else begin
            bus_rdata = 64'h0;
        end
    end

    assign req_valid = st_q.req;
    assign req_write = st_q.req_write;
    assign req_code  = st_q.req_code;
    assign req_len   = st_q.req_len;
    assign dat_ready = (st_q.phase == PH_FILL);

    assign cur_rdy   = st_q.rdy;
    assign cur_eom   = st_q.eom;
    assign cur_owner = st_q.owner;
    assign cur_psize = st_q.psize;
endmodule

// File: rtl/mbx_ctrl_chk.sv
module mbx_ctrl_chk #(
    parameter int WIN_BYTES = 1024,
    parameter int AW        = 8
) (
    input logic          clk,
    input logic          rst_n,
    input logic          req_valid,
    input logic          dat_ready,
    input logic [AW-1:0] bus_addr,
    input logic [63:0]   bus_rdata,
    input logic          cur_rdy,
    input logic          cur_eom,
    input logic          cur_owner,
    input logic [15:0]   cur_psize
);
    // R3
    req_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |=> !req_valid);

    // R9
    cmpl_reads_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_addr == '0) |-> !bus_rdata[6]);

    // R2
    owner_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_addr == '0) |-> !bus_rdata[5]);

    // R12
    fill_not_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
        dat_ready |-> !cur_rdy);

    // R7
    full_packet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cur_rdy && !cur_eom) |-> (cur_psize == 16'(WIN_BYTES)));

    // R10
    release_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(cur_owner) |-> (!cur_rdy && (cur_psize == 16'h0000)));
endmodule

bind mbx_ctrl mbx_ctrl_chk #(.WIN_BYTES(WIN_BYTES), .AW(AW)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_valid (req_valid),
    .dat_ready (dat_ready),
    .bus_addr  (bus_addr),
    .bus_rdata (bus_rdata),
    .cur_rdy   (cur_rdy),
    .cur_eom   (cur_eom),
    .cur_owner (cur_owner),
    .cur_psize (cur_psize)
);

// File: tb/sim_mbx_ctrl.sv
module sim_mbx_ctrl;
    timeunit 1ns;
    timeprecision 100ps;

    localparam int TMO = 16;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_wr = 1'b0;
    logic [7:0]  bus_addr = 8'd0;
    logic [63:0] bus_wdata = 64'd0;
    logic [63:0] bus_rdata;
    logic        req_valid, req_write, dat_ready;
    logic [7:0]  req_code;
    logic [15:0] req_len;
    logic        rsp_valid = 1'b0;
    logic [7:0]  rsp_status = 8'd0;
    logic [15:0] rsp_msg_len = 16'd0;
    logic        dat_valid = 1'b0;
    logic [63:0] dat_qword;
    int          sent_cnt = 0;

    int    total = 0;
    int    bad = 0;
    string cur_tag = "R1";
    bit    done = 1'b0;

    always #2 clk = ~clk;

    mbx_ctrl #(.TIMEOUT_CYC(TMO)) u0 (
        .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .req_valid(req_valid),
        .req_write(req_write), .req_code(req_code), .req_len(req_len),
        .rsp_valid(rsp_valid), .rsp_status(rsp_status), .rsp_msg_len(rsp_msg_len),
        .dat_valid(dat_valid), .dat_qword(dat_qword), .dat_ready(dat_ready)
    );

    function automatic logic [63:0] pat(input int i);
        return {32'hC0DE0000 + 32'(i), 32'(i) ^ 32'h5A5A5A5A};
    endfunction

    assign dat_qword = pat(sent_cnt);
    always @(posedge clk) if (dat_valid && dat_ready) sent_cnt <= sent_cnt + 1;

    task automatic chk(input string r, input logic [63:0] got, input logic [63:0] exp);
        total++;
        if (got !== exp) begin
            bad++;
            $display("FAIL %s got=%h exp=%h t=%0t", r, got, exp, $time);
        end
    endtask

    // ---------------- behavioural reference model ----------------
    bit          m_owner, m_run, m_dir, m_som, m_eom, m_rdy, m_req, m_reqw;
    int          m_ph, m_st, m_psz, m_msz, m_rem, m_idx, m_qw, m_cnt, m_code, m_len;
    logic [63:0] m_win [128];
    bit          m_known [128];

    function automatic logic [63:0] m_ctrl();
        return {16'(m_msz), 16'h0, 16'(m_psz), 8'(m_st), m_rdy, 1'b0, 1'b0,
                m_owner, m_eom, m_som, m_dir, m_run};
    endfunction

    task automatic m_release();
        m_owner = 0; m_ph = 0; m_run = 0; m_dir = 0; m_som = 0; m_eom = 0;
        m_rdy = 0; m_st = 0; m_psz = 0; m_msz = 0; m_rem = 0; m_idx = 0; m_qw = 0;
    endtask

    task automatic m_load();
        int b;
        b = (m_rem > 1024) ? 1024 : m_rem;
        m_psz = b; m_qw = (b + 7) / 8; m_eom = (m_rem <= 1024);
        m_idx = 0; m_run = 1; m_rdy = 0; m_ph = 2;
    endtask

    task automatic m_start(input logic [63:0] w);
        int len, qw, ix, code;
        len = int'(w[31:16]);
        qw = (len + 7) / 8;
        ix = (w[1] && qw != 0 && qw <= 128) ? qw - 1 : 0;
        code = int'(m_win[ix][7:0]);
        m_run = 1; m_dir = w[1]; m_som = 1; m_eom = 1; m_psz = len;
        m_st = 0; m_rdy = 0; m_msz = 0;
        if (!(code == 4 || code == 8 || code == 16 || code == 20)) begin
            m_st = 2; m_run = 0; m_rdy = 1; m_ph = 4;
        end else if (m_dir && len > 1024) begin
            m_st = 3; m_run = 0; m_rdy = 1; m_ph = 4;
        end else begin
            m_ph = 1; m_req = 1; m_reqw = m_dir; m_code = code; m_len = len; m_cnt = 0;
        end
    endtask

    always @(posedge clk) begin
        if (!rst_n) begin
            m_release(); m_req = 0; m_reqw = 0; m_code = 0; m_len = 0; m_cnt = 0;
            foreach (m_known[i]) m_known[i] = 0;
        end else begin
            int p;
            bit cw, cmpl;
            p = m_ph; m_req = 0;
            cw = bus_wr && bus_addr == 0;
            cmpl = cw && bus_wdata[6];
            case (p)
                0: begin
                    if (!m_owner) begin
                        if (bus_wr && bus_addr == 1) begin
                            m_win[0] = bus_wdata; m_known[0] = 1; m_owner = 1;
                        end
                    end else if (cmpl) m_release();
                    else if (cw && bus_wdata[0] && bus_wdata[2] && bus_wdata[3]) m_start(bus_wdata);
                    else if (bus_wr && bus_addr >= 1 && bus_addr <= 128) begin
                        m_win[bus_addr - 1] = bus_wdata; m_known[bus_addr - 1] = 1;
                    end
                end
                1: begin
                    if (rsp_valid) begin
                        m_run = 0; m_rdy = 1;
                        if (m_dir) begin m_st = rsp_status; m_ph = 4; end
                        else if (rsp_status != 8'h40) begin m_st = rsp_status; m_psz = 0; m_ph = 4; end
                        else if (rsp_msg_len > 4096) begin m_st = 3; m_psz = 0; m_ph = 4; end
                        else begin
                            m_st = 8'h40; m_msz = rsp_msg_len; m_som = 1; m_rem = rsp_msg_len;
                            if (m_rem == 0) begin m_psz = 0; m_eom = 1; m_ph = 3; end
                            else m_load();
                        end
                    end else if (m_cnt == TMO - 1) begin
                        m_st = 8'h80; m_psz = 0; m_run = 0; m_rdy = 1; m_ph = 4;
                    end else m_cnt++;
                end
                2: begin
                    if (dat_valid) begin
                        m_win[m_idx] = dat_qword; m_known[m_idx] = 1;
                        if (m_idx == m_qw - 1) begin m_rdy = 1; m_run = 0; m_ph = 3; end
                        else m_idx++;
                    end
                end
                3: if (cmpl) begin
                    if (m_eom) m_release();
                    else begin m_rem -= 1024; m_som = 0; m_load(); end
                end
                4: if (cmpl) m_release();
                default: ;
            endcase
        end
    end

    // per-cycle comparison against the model
    always @(negedge clk) begin
        #1;
        if (rst_n) begin
            if (bus_addr == 0) chk({cur_tag, " ctrl"}, bus_rdata, m_ctrl());
            else if (bus_addr <= 128 && m_known[bus_addr - 1])
                chk({cur_tag, " window"}, bus_rdata, m_win[bus_addr - 1]);
            chk({cur_tag, " req_valid"}, 64'(req_valid), 64'(m_req));
            if (m_req) chk({cur_tag, " req fields"}, {39'd0, req_write, req_code, req_len},
                           {39'd0, m_reqw, 8'(m_code), 16'(m_len)});
            chk({cur_tag, " dat_ready"}, 64'(dat_ready), 64'(m_ph == 2));
        end
    end

    // ---------------- stimulus helpers ----------------
    task automatic wr(input logic [7:0] a, input logic [63:0] d);
        @(negedge clk);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_wr = 1'b0; bus_addr = 8'd0;
    endtask

    task automatic peek(input logic [7:0] a, output logic [63:0] v);
        bus_addr = a;
        #0.5;
        v = bus_rdata;
    endtask

    task automatic respond(input logic [7:0] s, input logic [15:0] l);
        @(negedge clk);
        rsp_valid = 1'b1; rsp_status = s; rsp_msg_len = l;
        @(negedge clk);
        rsp_valid = 1'b0;
    endtask

    task automatic wait_rdy();
        logic [63:0] v;
        for (int i = 0; i < 3000; i++) begin
            peek(8'd0, v);
            if (v[7]) break;
            @(negedge clk);
        end
    endtask

    function automatic logic [63:0] cmd(input bit dir, input int len);
        return {32'd0, 16'(len), 12'd0, 2'b11, dir, 1'b1};
    endfunction

    localparam logic [63:0] CMPL = 64'h40;

    task automatic summary();
        if (!done) begin
            done = 1'b1;
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        total++; bad++;
        $display("FAIL watchdog expired");
        summary();
    end

    initial begin
        logic [63:0] v;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R1: reset state
        cur_tag = "R1";
        peek(8'd0, v);
        chk("R1 ctrl after reset", v, 64'h0);
        chk("R1 req_valid", 64'(req_valid), 64'h0);
        chk("R1 dat_ready", 64'(dat_ready), 64'h0);

        // R2: free mailbox ignores control writes, claim via first qword
        cur_tag = "R2";
        wr(8'd0, cmd(1'b0, 8));
        peek(8'd0, v); chk("R2 ctrl write ignored while free", v, 64'h0);
        chk("R2 no request while free", 64'(req_valid), 64'h0);
        wr(8'd1, 64'h1111_0000_0000_0001);
        peek(8'd0, v); chk("R2 owner after claim", v, 64'h10);
        peek(8'd1, v); chk("R2 claim qword stored", v, 64'h1111_0000_0000_0001);

        // R3 / R5: write command
        cur_tag = "R3";
        wr(8'd2, 64'hAB);
        wr(8'd3, 64'h08);
        wr(8'd0, cmd(1'b1, 24));
        chk("R3 req_valid", 64'(req_valid), 64'h1);
        chk("R3 req fields", {req_write, req_code, req_len}, {1'b1, 8'h08, 16'd24});
        peek(8'd0, v); chk("R3 run set ready clear", {v[7], v[0]}, 2'b01);
        @(negedge clk);
        chk("R3 single-cycle request", 64'(req_valid), 64'h0);
        cur_tag = "R5";
        repeat (4) @(negedge clk);
        respond(8'h40, 16'd0);
        peek(8'd0, v); chk("R5 write result", {v[15:8], v[7], v[0]}, {8'h40, 1'b1, 1'b0});
        cur_tag = "R10";
        wr(8'd0, CMPL);
        peek(8'd0, v); chk("R10 release after write result", v, 64'h0);

        // R4: unknown command code
        cur_tag = "R4";
        wr(8'd1, 64'h33);
        wr(8'd0, cmd(1'b0, 8));
        chk("R4 no request", 64'(req_valid), 64'h0);
        peek(8'd0, v); chk("R4 bad code status", {v[15:8], v[7]}, {8'h02, 1'b1});
        wr(8'd0, CMPL);
        peek(8'd0, v); chk("R10 release after bad code", v, 64'h0);

        // R6: timeout
        cur_tag = "R6";
        wr(8'd1, 64'h10);
        wr(8'd0, cmd(1'b0, 8));
        chk("R3 read code from first qword", {req_write, req_code}, {1'b0, 8'h10});
        repeat (TMO - 1) @(negedge clk);
        peek(8'd0, v); chk("R6 not yet expired", 64'(v[7]), 64'h0);
        @(negedge clk);
        peek(8'd0, v); chk("R6 timeout status", {v[31:16], v[15:8], v[7]}, {16'd0, 8'h80, 1'b1});
        wr(8'd0, CMPL);
        peek(8'd0, v); chk("R10 release after timeout", v, 64'h0);

        // R5: read command rejected by responder
        cur_tag = "R5";
        wr(8'd1, 64'h14);
        wr(8'd0, cmd(1'b0, 8));
        respond(8'h91, 16'd100);
        peek(8'd0, v); chk("R5 read error status", {v[31:16], v[15:8], v[7]}, {16'd0, 8'h91, 1'b1});
        wr(8'd0, CMPL);

        // R11: oversize read reply and oversize write request
        cur_tag = "R11";
        wr(8'd1, 64'h10);
        wr(8'd0, cmd(1'b0, 8));
        respond(8'h40, 16'd5000);
        peek(8'd0, v); chk("R11 read too long", {v[31:16], v[15:8]}, {16'd0, 8'h03});
        wr(8'd0, CMPL);
        wr(8'd1, 64'h04);
        wr(8'd0, cmd(1'b1, 2000));
        chk("R11 no request for big write", 64'(req_valid), 64'h0);
        peek(8'd0, v); chk("R11 write too long", 64'(v[15:8]), 64'h03);
        wr(8'd0, CMPL);

        // R7 / R8 / R9 / R12: three-packet read of 2500 bytes
        cur_tag = "R7";
        wr(8'd1, 64'h14);
        wr(8'd0, cmd(1'b0, 8));
        respond(8'h40, 16'd2500);
        chk("R8 loading after success", 64'(dat_ready), 64'h1);
        dat_valid = 1'b1;
        cur_tag = "R12";
        repeat (3) @(negedge clk);
        wr(8'd0, CMPL);
        peek(8'd0, v); chk("R12 complete ignored while loading", {v[7], v[4], v[6]}, 3'b010);
        wr(8'd5, 64'hDEAD);
        cur_tag = "R7";
        wait_rdy();
        peek(8'd0, v);
        chk("R7 first packet", {v[63:48], v[31:16], v[3], v[2]}, {16'd2500, 16'd1024, 1'b0, 1'b1});
        peek(8'd1, v);   chk("R8 first qword", v, pat(0));
        peek(8'd5, v);   chk("R12 window write ignored while loading", v, pat(4));
        peek(8'd128, v); chk("R8 last qword of packet", v, pat(127));
        cur_tag = "R9";
        wr(8'd0, CMPL);
        peek(8'd0, v); chk("R9 ready cleared by complete", {v[7], v[6]}, 2'b00);
        chk("R9 next packet loading", 64'(dat_ready), 64'h1);
        cur_tag = "R7";
        wait_rdy();
        peek(8'd0, v); chk("R7 middle packet", {v[31:16], v[3], v[2]}, {16'd1024, 1'b0, 1'b0});
        peek(8'd1, v); chk("R8 second packet first qword", v, pat(128));
        wr(8'd0, CMPL);
        wait_rdy();
        dat_valid = 1'b0;
        peek(8'd0, v); chk("R7 last packet", {v[31:16], v[3], v[2]}, {16'd452, 1'b1, 1'b0});
        peek(8'd57, v); chk("R8 rounded last qword", v, pat(312));
        cur_tag = "R10";
        wr(8'd0, CMPL);
        peek(8'd0, v); chk("R10 release after final packet", v, 64'h0);

        // R7: empty reply
        cur_tag = "R7";
        wr(8'd1, 64'h10);
        wr(8'd0, cmd(1'b0, 8));
        respond(8'h40, 16'd0);
        peek(8'd0, v); chk("R7 empty reply", {v[31:16], v[7], v[3], v[2]}, {16'd0, 3'b111});
        wr(8'd0, CMPL);

        // R10: release with no command active
        cur_tag = "R10";
        wr(8'd1, 64'h10);
        wr(8'd0, CMPL);
        peek(8'd0, v); chk("R10 release while idle", v, 64'h0);

        repeat (4) @(negedge clk);
        summary();
    end
endmodule